// File: doc/BRIEF.md
# Segmented Z-Hit Coincidence Former

This block forms the z-position hit pattern for one wire-based z-trigger layer. Such a layer is built from two consecutive axial wire layers and two consecutive stereo wire layers. Each axial/stereo neighbouring pair has already been turned into a per-segment vector of tower bits, where each tower bit stands for one computed z-position. The block takes these two pair vectors, already split into azimuthal segments and registered on the system clock, and keeps a tower bit only when both pairs report it in the same segment. A hit seen by only one pair is treated as uncorrelated noise and dropped.

The surviving coincidences of each segment are then ORed with those of the two azimuthally adjacent segments, with the segment index wrapping around the ring, so a track that crosses a segment boundary still appears to the tower-matching stage. The result is registered once and presented as a flat vector. Segment `s`, tower `t` sits at bit `s*TOWERS + t` on every vector port. Wire geometry and drift-time handling are done upstream.

Top module: `zc_former`

## Requirements
- R1: A synchronous active-high reset clears the whole output vector; after any clock edge with `rst` high, `zmap_q` is all zeros whatever the inputs.
- R2: A tower bit counts as a coincidence only when bit `s*TOWERS+t` is set on both `pair_a_z` and `pair_b_z`. Segment `s` and tower `t` must be the same on both inputs.
- R3: A hit present on only one of the two pair inputs has no effect; when `pair_a_z & pair_b_z` is zero, `zmap_q` is zero on the next cycle.
- R4: Output bit (s, t) is the OR of the coincidences at tower t in segments s-1, s and s+1.
- R5: Segment indexing wraps: with 8 segments, segment 0 and segment 7 are neighbours of each other.
- R6: A coincidence at tower t never sets any output bit at a tower other than t.
- R7: `zmap_q` after clock edge k reflects the inputs sampled at edge k (one register stage), and it follows new inputs on every cycle.
- R8: A coincidence in one segment leaves every segment at azimuthal distance two or more untouched, so a single coincidence sets at most three output bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pair_a_z | input | SEGS*TOWERS (128) | Tower bits from the first axial/stereo pair, bit s*TOWERS+t |
| pair_b_z | input | SEGS*TOWERS (128) | Tower bits from the second axial/stereo pair, same layout |
| zmap_q | output | SEGS*TOWERS (128) | Registered coincidence pattern after the neighbour-segment OR |

## Verification
Every result of this block is due exactly one clock edge after its inputs are sampled. That covers the coincidence, the neighbour OR and the clearing by reset. The bench drives new inputs on the falling edge and computes the expected vector for them at once. It compares `zmap_q` on the next falling edge, after the single register has loaded. Directed phases place lone coincidences at interior segments, at both wrap-around ends and at several towers at once. Separate phases drive single-pair noise only, random patterns that change every cycle, and a reset asserted in the middle of traffic. Each comparison is tagged with the requirement its phase covers.

// File: rtl/zc_pkg.sv
package zc_pkg;

  localparam int ZC_SEGS   = 8;
  localparam int ZC_TOWERS = 16;

  // Index of the segment on the low side, wrapping across the ring.
  function automatic int seg_prev(input int s, input int n);
    return (s == 0) ? n - 1 : s - 1;
  endfunction

  // Index of the segment on the high side, wrapping across the ring.
  function automatic int seg_next(input int s, input int n);
    return (s == n - 1) ? 0 : s + 1;
  endfunction

  // Whether segment s has a real neighbour on the given side without wrap.
  function automatic bit has_side(input int s, input int n, input bit high);
    return high ? (s != n - 1) : (s != 0);
  endfunction

endpackage

// File: rtl/zc_coinc.sv
module zc_coinc #(
  parameter int SEGS   = zc_pkg::ZC_SEGS,
  parameter int TOWERS = zc_pkg::ZC_TOWERS,
  localparam int W     = SEGS * TOWERS
) (
  input  logic [W-1:0] pair_a,
  input  logic [W-1:0] pair_b,
  output logic [W-1:0] coinc
);

  // Per-segment agreement of both layer pairs on the same tower.
  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign coinc[s*TOWERS +: TOWERS] = pair_a[s*TOWERS +: TOWERS]
                                     & pair_b[s*TOWERS +: TOWERS];
  end

endmodule

// File: rtl/zc_spread.sv
module zc_spread #(
  parameter int SEGS   = zc_pkg::ZC_SEGS,
  parameter int TOWERS = zc_pkg::ZC_TOWERS,
  parameter bit WRAP   = 1'b1,
  localparam int W     = SEGS * TOWERS
) (
  input  logic [W-1:0] coinc,
  output logic [W-1:0] spread
);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    localparam int  LO     = zc_pkg::seg_prev(s, SEGS);
    localparam int  HI     = zc_pkg::seg_next(s, SEGS);
    localparam bit  USE_LO = WRAP || zc_pkg::has_side(s, SEGS, 1'b0);
    localparam bit  USE_HI = WRAP || zc_pkg::has_side(s, SEGS, 1'b1);

    logic [TOWERS-1:0] own_v;
    logic [TOWERS-1:0] lo_v;
    logic [TOWERS-1:0] hi_v;

    assign own_v = coinc[s*TOWERS +: TOWERS];

    if (USE_LO) begin : g_lo
      assign lo_v = coinc[LO*TOWERS +: TOWERS];
    end else begin : g_lo_none
      assign lo_v = '0;
    end

    if (USE_HI) begin : g_hi
      assign hi_v = coinc[HI*TOWERS +: TOWERS];
    end else begin : g_hi_none
      assign hi_v = '0;
    end

    assign spread[s*TOWERS +: TOWERS] = own_v | lo_v | hi_v;
  end

endmodule

// File: rtl/zc_former.sv
module zc_former #(
  parameter int SEGS   = zc_pkg::ZC_SEGS,
  parameter int TOWERS = zc_pkg::ZC_TOWERS,
  parameter bit WRAP   = 1'b1,
  localparam int W     = SEGS * TOWERS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pair_a_z,
  input  logic [W-1:0] pair_b_z,
  output logic [W-1:0] zmap_q
);

  // Named internal events, brought out for the bound checker.
  logic [W-1:0] coinc_w;
  logic [W-1:0] spread_w;

  zc_coinc #(
    .SEGS   (SEGS),
    .TOWERS (TOWERS)
  ) u_coinc (
    .pair_a (pair_a_z),
    .pair_b (pair_b_z),
    .coinc  (coinc_w)
  );

  zc_spread #(
    .SEGS   (SEGS),
    .TOWERS (TOWERS),
    .WRAP   (WRAP)
  ) u_spread (
    .coinc  (coinc_w),
    .spread (spread_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zmap_q <= '0;
    end else begin
      zmap_q <= spread_w;
    end
  end

endmodule

// File: rtl/zc_former_chk.sv
module zc_former_chk #(
  parameter int SEGS   = zc_pkg::ZC_SEGS,
  parameter int TOWERS = zc_pkg::ZC_TOWERS,
  localparam int W     = SEGS * TOWERS
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pair_a_z,
  input logic [W-1:0] pair_b_z,
  input logic [W-1:0] coinc,
  input logic [W-1:0] spread,
  input logic [W-1:0] zmap_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (zmap_q == '0)); // R1

  AST_COINC_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((zmap_q & $past(coinc)) == $past(coinc))); // R2

  AST_SINGLE_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((pair_a_z & pair_b_z) == '0) |=> (zmap_q == '0)); // R3

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zmap_q == $past(spread))); // R7

  AST_SPREAD_BOUND: assert property (@(posedge clk) disable iff (rst)
    $countones(spread) <= 3 * $countones(coinc)); // R8

  AST_SPREAD_FROM_COINC: assert property (@(posedge clk) disable iff (rst)
    (coinc == '0) |-> (spread == '0)); // R4

endmodule

bind zc_former zc_former_chk #(
  .SEGS   (SEGS),
  .TOWERS (TOWERS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pair_a_z (pair_a_z),
  .pair_b_z (pair_b_z),
  .coinc    (coinc_w),
  .spread   (spread_w),
  .zmap_q   (zmap_q)
);

// File: tb/zc_former_bench.sv
module zc_former_bench;

  localparam int SEGS   = 8;
  localparam int TOWERS = 16;
  localparam int W      = SEGS * TOWERS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pair_a_z = '0;
  logic [W-1:0] pair_b_z = '0;
  logic [W-1:0] zmap_q;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  string cur_req = "R1";
  logic [W-1:0] exp_q = '0;
  bit exp_valid = 1'b0;

  always #5 clk = ~clk;

  zc_former u_zc_former (
    .clk      (clk),
    .rst      (rst),
    .pair_a_z (pair_a_z),
    .pair_b_z (pair_b_z),
    .zmap_q   (zmap_q)
  );

  // Behavioural model: each agreeing hit lights its own tower in three segments.
  function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic r);
    logic [W-1:0] res = '0;
    if (r) return res;
    for (int idx = 0; idx < W; idx++) begin
      if (a[idx] === 1'b1 && b[idx] === 1'b1) begin
        int seg = idx / TOWERS;
        int tw  = idx % TOWERS;
        for (int d = -1; d <= 1; d++) begin
          int tgt = (seg + d + SEGS) % SEGS;
          res[tgt*TOWERS + tw] = 1'b1;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [W-1:0] bitat(input int seg, input int tw);
    logic [W-1:0] v = '0;
    v[seg*TOWERS + tw] = 1'b1;
    return v;
  endfunction

  task automatic check_vec(input string req, input logic [W-1:0] act,
                           input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: check result of previous drive, then drive new inputs.
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    if (exp_valid) check_vec(cur_req, zmap_q, exp_q);
    rst      = r;
    pair_a_z = a;
    pair_b_z = b;
    exp_q    = model(a, b, r);
    exp_valid = 1'b1;
  endtask

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int k = 0; k < W; k += 32) v[k +: 32] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        failures++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [W-1:0] v;
    // R1: reset with busy inputs clears output
    cur_req = "R1";
    step(1'b1, '1, '1);
    step(1'b1, '1, '1);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);

    // R3: single-pair noise only
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin
      v = rnd();
      step(1'b0, v, ~v);
    end
    step(1'b0, rnd(), '0);
    step(1'b0, '0, rnd());
    step(1'b0, '0, '0);

    // R2 / R4 / R8: lone coincidence in an interior segment
    cur_req = "R4";
    step(1'b0, bitat(3, 5), bitat(3, 5) | bitat(2, 5) ^ '0);
    step(1'b0, '0, '0);
    cur_req = "R2";
    step(1'b0, bitat(3, 5), bitat(4, 5));
    step(1'b0, '0, '0);
    cur_req = "R8";
    step(1'b0, bitat(3, 9), bitat(3, 9));
    @(negedge clk);
    check_vec("R8", zmap_q & (bitat(1, 9) | bitat(5, 9) | bitat(0, 9)), '0);
    check_vec("R4", zmap_q, bitat(2, 9) | bitat(3, 9) | bitat(4, 9));
    exp_valid = 1'b0;
    step(1'b0, '0, '0);

    // R5: wrap at both ends of the ring
    cur_req = "R5";
    step(1'b0, bitat(0, 0), bitat(0, 0));
    @(negedge clk);
    check_vec("R5", zmap_q, bitat(7, 0) | bitat(0, 0) | bitat(1, 0));
    exp_valid = 1'b0;
    step(1'b0, bitat(7, 15), bitat(7, 15));
    step(1'b0, bitat(0, 3) | bitat(7, 3), bitat(0, 3) | bitat(7, 3));
    step(1'b0, '0, '0);

    // R6: several towers at once stay in their own tower
    cur_req = "R6";
    step(1'b0, bitat(2, 1) | bitat(5, 14) | bitat(6, 7),
               bitat(2, 1) | bitat(5, 14) | bitat(6, 7) | bitat(6, 8));
    step(1'b0, bitat(4, 0) | bitat(4, 15), bitat(4, 0) | bitat(4, 15));
    step(1'b0, '0, '0);

    // R7: patterns changing every cycle
    cur_req = "R7";
    for (int i = 0; i < 200; i++) begin
      v = rnd();
      step(1'b0, v, v | rnd());
    end
    for (int i = 0; i < 200; i++) step(1'b0, rnd(), rnd());

    // R1: reset in the middle of traffic
    cur_req = "R1";
    step(1'b1, '1, '1);
    step(1'b0, rnd(), rnd());
    step(1'b1, rnd(), rnd());
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule